// File: doc/BRIEF.md
# Bi-phase Answer Frame Transmitter

This block sends a one-byte answer on a two-wire lighting control bus using bi-phase (Manchester-style) coding. An upstream command decoder offers the answer byte on a valid/ready interface. Once the block takes the byte, it drives a line-pull output through a fixed frame: a start bit of logical 1, the eight answer bits most significant first, and then two bit times of released line. After that it returns to idle and accepts the next byte.

Timing comes from a half-bit tick enable that the surrounding logic pulses once per half-bit period. A single position counter steps once per tick. Its upper bits select the bit slot, and its least significant bit selects the first or second half of that slot. A positive answer is the byte 0xFF. A negative answer is sent by not offering a byte at all, so the line stays released.

Back-pressure works as follows. `ans_ready` is high only while no frame is in progress. A byte is taken on a rising clock edge where `ans_valid` and `ans_ready` are both high. While a frame runs, the source may hold `ans_valid` and change `ans_data` freely; neither affects the frame in flight.

Top module: `bft_top`

## Requirements
- R1: After reset, and whenever no frame is in progress, `line_pull` is 0 (released), `busy` is 0 and `ans_ready` is 1.
- R2: A byte is accepted on a clock edge with `ans_valid` and `ans_ready` both high; from the next cycle `busy` is 1 and `ans_ready` is 0.
- R3: The first two half periods after acceptance form the start bit: `line_pull` is 1 in the first half and 0 in the second.
- R4: Bit slots 1 to 8 carry `ans_data[7]` down to `ans_data[0]`. A 1 is sent as pull (1) then release (0), and a 0 as release (0) then pull (1).
- R5: Slots 9 and 10 (four half periods) keep `line_pull` at 0 while `busy` stays 1. `busy` falls at the edge where the 22nd half-bit tick since acceptance is sampled.
- R6: `line_pull` and `busy` change during a frame only at clock edges where `half_tick` is sampled high.
- R7: While `busy` is 1, `ans_valid` and `ans_data` have no effect on the frame being sent.
- R8: With `ans_valid` held low, `line_pull` stays 0 regardless of `half_tick` (negative answer: no frame).
- R9: The byte 0xFF (positive answer) gives nine consecutive pull-then-release bit slots, start bit included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_tick | input | 1 | One-cycle enable per half-bit period |
| ans_valid | input | 1 | Answer byte offered |
| ans_ready | output | 1 | Block can take a byte (no frame in progress) |
| ans_data | input | 8 | Answer byte |
| line_pull | output | 1 | 1 = pull bus low, 0 = release |
| busy | output | 1 | Frame in progress |

## Verification
After acceptance, `busy` and the start bit's first-half pull appear one clock edge later. Each later line level appears one edge after the edge where `half_tick` is sampled high, and holds until the next such edge. `busy` drops at the edge that samples the 22nd tick. The bench drives inputs and samples outputs on falling clock edges, and it compares the line against its computed level in every cycle of every half period, so both a wrong level and an early change are caught. The gap between ticks varies from one to four cycles.

// File: rtl/bft_pkg.sv
package bft_pkg;
  // Level driven for one half of a bi-phase bit: a 1 pulls in its first half.
  function automatic logic half_level(input logic bit_val, input logic second_half);
    return bit_val ^ second_half;
  endfunction

  function automatic int slot_count(input int data_w, input int stop_bits);
    return 1 + data_w + stop_bits;
  endfunction
endpackage

// File: rtl/bft_pos_counter.sv
module bft_pos_counter #(
  parameter int POS_W      = 5,
  parameter int LAST_POS   = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tick,
  output logic             active,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] LAST = POS_W'(LAST_POS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      pos    <= '0;
    end else if (start) begin
      active <= 1'b1;
      pos    <= '0;
    end else if (active && tick) begin
      if (pos == LAST) begin
        active <= 1'b0;
        pos    <= '0;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bft_slot_mux.sv
module bft_slot_mux #(
  parameter int DATA_W = 8,
  parameter int SLOT_W = 4,
  parameter int POS_W  = 5
) (
  input  logic              active,
  input  logic [POS_W-1:0]  pos,
  input  logic [DATA_W-1:0] frame_byte,
  output logic              pull
);
  import bft_pkg::*;
  localparam int SLOT_SPAN = 1 << SLOT_W;

  logic [SLOT_SPAN-1:0] slot_bit;
  logic [SLOT_SPAN-1:0] slot_live;
  logic [SLOT_W-1:0]    slot;
  logic                 second_half;

  assign slot        = pos[POS_W-1:1];
  assign second_half = pos[0];

  // Slot 0 is the start bit, slots 1..DATA_W the byte MSB first, the rest idle.
  for (genvar i = 0; i < SLOT_SPAN; i++) begin : g_slot
    if (i == 0) begin : g_start
      assign slot_bit[i]  = 1'b1;
      assign slot_live[i] = 1'b1;
    end else if (i <= DATA_W) begin : g_data
      assign slot_bit[i]  = frame_byte[DATA_W-i];
      assign slot_live[i] = 1'b1;
    end else begin : g_idle
      assign slot_bit[i]  = 1'b0;
      assign slot_live[i] = 1'b0;
    end
  end

  always_comb begin
    pull = active && slot_live[slot] && half_level(slot_bit[slot], second_half);
  end
endmodule

// File: rtl/bft_top.sv
module bft_top #(
  parameter int DATA_W    = 8,
  parameter int STOP_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_tick,
  input  logic              ans_valid,
  output logic              ans_ready,
  input  logic [DATA_W-1:0] ans_data,
  output logic              line_pull,
  output logic              busy
);
  import bft_pkg::*;
  localparam int N_SLOTS = slot_count(DATA_W, STOP_BITS);
  localparam int SLOT_W  = $clog2(N_SLOTS);
  localparam int POS_W   = SLOT_W + 1;
  localparam int N_HALF  = 2 * N_SLOTS;

  logic              accept;
  logic [POS_W-1:0]  pos;
  logic [DATA_W-1:0] frame_byte;

  assign ans_ready = !busy;
  assign accept    = ans_valid && ans_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)      frame_byte <= '0;
    else if (accept) frame_byte <= ans_data;
  end

  bft_pos_counter #(.POS_W(POS_W), .LAST_POS(N_HALF - 1)) u_pos (
    .clk(clk), .rst_n(rst_n), .start(accept), .tick(half_tick),
    .active(busy), .pos(pos)
  );

  bft_slot_mux #(.DATA_W(DATA_W), .SLOT_W(SLOT_W), .POS_W(POS_W)) u_mux (
    .active(busy), .pos(pos), .frame_byte(frame_byte), .pull(line_pull)
  );
endmodule

// File: rtl/bft_checker.sv
module bft_checker (
  input logic clk,
  input logic rst_n,
  input logic half_tick,
  input logic ans_valid,
  input logic ans_ready,
  input logic line_pull,
  input logic busy
);
  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !line_pull);

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ans_valid && ans_ready) |=> (busy && !ans_ready));

  p_start_pull_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> line_pull);

  p_hold_no_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !half_tick) |=> ($stable(line_pull) && busy));

  p_ignore_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ans_valid && !half_tick) |=> (busy && $stable(line_pull)));
endmodule

bind bft_top bft_checker u_bft_checker (
  .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .ans_valid(ans_valid),
  .ans_ready(ans_ready), .line_pull(line_pull), .busy(busy)
);

// File: tb/bft_top_bench.sv
module bft_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       half_tick = 1'b0;
  logic       ans_valid = 1'b0;
  logic       ans_ready;
  logic [7:0] ans_data = '0;
  logic       line_pull;
  logic       busy;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bft_top u_bft_top (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .ans_valid(ans_valid),
    .ans_ready(ans_ready), .ans_data(ans_data), .line_pull(line_pull), .busy(busy)
  );

  // Expected line level for half period k (0..21) of a frame carrying b.
  function automatic logic exp_pull(input logic [7:0] b, input int k);
    int slot = k / 2;
    logic sec = logic'(k % 2);
    logic v;
    if (slot == 0) v = 1'b1;
    else if (slot <= 8) v = b[8 - slot];
    else return 1'b0;
    return v ^ sec;
  endfunction

  task automatic check(input string req, input logic act, input logic expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, expv, $time);
    end
  endtask

  function automatic string req_of(input int k, input logic [7:0] b);
    if (k < 2) return "R3";
    if (k < 18) return (b == 8'hFF) ? "R9" : "R4";
    return "R5";
  endfunction

  task automatic send_frame(input logic [7:0] b, input int gap, input bit noisy);
    @(negedge clk);
    check("R1", ans_ready, 1'b1);
    ans_valid = 1'b1; ans_data = b; half_tick = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R2", busy, 1'b1);
    check("R2", ans_ready, 1'b0);
    for (int k = 0; k < 22; k++) begin
      for (int i = 0; i < gap; i++) begin
        check(req_of(k, b), line_pull, exp_pull(b, k));
        check((i == 0) ? "R5" : "R6", busy, 1'b1);
        // R7: traffic on the byte interface while a frame runs
        ans_valid = noisy ? 1'b1 : 1'($urandom_range(0, 1));
        ans_data  = ~b ^ 8'($urandom);
        half_tick = (i == gap - 1);
        @(posedge clk);
        @(negedge clk);
      end
    end
    ans_valid = 1'b0; half_tick = 1'b0;
    check("R5", busy, 1'b0);
    check("R1", line_pull, 1'b0);
    check("R1", ans_ready, 1'b1);
  endtask

  initial begin : watchdog
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h1A2B);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", line_pull, 1'b0);
    check("R1", busy, 1'b0);
    check("R1", ans_ready, 1'b1);
    rst_n = 1'b1;
    // R8: ticks with no request keep the line released
    for (int i = 0; i < 12; i++) begin
      half_tick = logic'(i % 2);
      @(posedge clk); @(negedge clk);
      check("R8", line_pull, 1'b0);
      check("R8", busy, 1'b0);
    end
    half_tick = 1'b0;
    send_frame(8'hFF, 1, 1'b0);
    send_frame(8'h00, 2, 1'b1);
    send_frame(8'h80, 3, 1'b0);
    send_frame(8'h01, 1, 1'b1);
    send_frame(8'hA5, 4, 1'b1);
    send_frame(8'hFF, 3, 1'b1);
    for (int n = 0; n < 10; n++)
      send_frame(8'($urandom), int'($urandom_range(1, 4)), 1'($urandom_range(0, 1)));
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule